// File: doc/BRIEF.md
# Deficit Round Robin Packet Scheduler

This block decides which flow sends the next packet onto a shared output link. It is byte-fair across flows whose packets have different lengths. Each flow owns a small queue of packet lengths and a deficit counter. Flows that hold packets wait in a circular service order. When a flow's turn comes, its quantum is credited to its deficit. The flow then sends head packets for as long as each one fits in the deficit that remains. The flow then rotates to the back of the order, keeping what is left of its deficit. A flow that runs dry forfeits its leftover credit.

The block carries packet lengths only; payload storage is elsewhere. Packet descriptors arrive one per cycle as a flow number and a byte length. The link takes grants through a valid/ready pair. The grant path doubles as the link-ready indication: while it is low, the block makes no scheduling progress. Each flow's quantum comes from a static configuration bus and acts as that flow's weight. Every decision costs a fixed number of cycles, whatever the number of flows.

Top module: `drr_sched`

## Requirements
- R1: After reset no grant is offered, every deficit counter is zero and every flow queue accepts descriptors (`enq_ready` high).
- R2: Each turn of a flow first adds that flow's quantum to its deficit. The quantum is the flow's `LEN_W`-bit slice of `quantum_cfg`, with flow i at bits [i*LEN_W +: LEN_W]. A slice of zero selects the default quantum of 200 bytes.
- R3: During its turn a flow is granted its head packet whenever the packet's length is at most the current deficit. The deficit then drops by that length, and this repeats with the next packet.
- R4: When the next head packet is longer than the remaining deficit, the turn ends. The flow goes to the back of the service order and keeps its remaining deficit for its next turn.
- R5: When a flow's last queued packet is granted, its deficit is cleared to zero and it leaves the service order.
- R6: A flow whose queue was empty joins the back of the service order when a descriptor is accepted for it.
- R7: Flows take turns in the circular order set by R4 and R6. With all queues loaded before service starts, turns follow the order in which the flows first received a descriptor.
- R8: At most one grant completes per cycle (`gnt_valid` and `gnt_ready` both high). While `gnt_valid` is high and `gnt_ready` is low, `gnt_valid`, `gnt_flow` and `gnt_len` hold steady. Packets that fit within one turn are granted on consecutive cycles.
- R9: While `gnt_ready` is low, no turn starts and no deficit changes. Only enqueues are taken.
- R10: A descriptor is dropped, with no effect on any grant, in two cases: its flow already holds `FIFO_DEPTH` (default 8) packets, or its length is zero. `enq_ready` is low exactly when the addressed flow's queue is full.
- R11: Starting a turn takes one cycle. If the head fits, the grant is offered in the cycle right after the turn starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Descriptor present |
| enq_flow | input | FLOW_W | Flow number of the descriptor |
| enq_len | input | LEN_W | Packet length in bytes, 1 to 2047 |
| enq_ready | output | 1 | Addressed flow queue has room |
| quantum_cfg | input | NUM_FLOWS*LEN_W | Per-flow quantum, zero means default |
| gnt_valid | output | 1 | A packet grant is offered |
| gnt_ready | input | 1 | Link ready; completes a grant and lets scheduling advance |
| gnt_flow | output | FLOW_W | Flow of the offered packet |
| gnt_len | output | LEN_W | Length of the offered packet |

## Verification
The bench loads queues while the link is held off and then compares the whole grant sequence against a behavioural round-robin model. The weights are uneven, and one pattern forces flows to skip turns, so a design that credits the quantum twice, drops the leftover deficit on requeue, or reorders flows sends the wrong packet. Separate timed cases cover three faults. A flow joining at the front instead of the back serves the new flow early. A drained flow that keeps its stale credit gets its next packet one turn too soon. A full queue that still accepts a descriptor, or a zero-length descriptor that is not dropped, shows up as an extra grant. Stall and back-to-back cases catch a grant that changes under a low ready, or a bubble between packets of one turn.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int LEN_W = 11;
  localparam int DEF_W = LEN_W + 1;

  typedef logic [LEN_W-1:0] len_t;
  typedef logic [DEF_W-1:0] def_t;

  // credit granted at the start of a turn; zero quantum picks the default
  function automatic def_t visit_credit(def_t d, len_t q, len_t dflt);
    len_t eff;
    eff = (q == '0) ? dflt : q;
    return d + DEF_W'(eff);
  endfunction

  function automatic logic head_fits(len_t h, def_t d);
    return DEF_W'(h) <= d;
  endfunction

  function automatic def_t charge(def_t d, len_t h);
    return d - DEF_W'(h);
  endfunction
endpackage

// File: rtl/drr_len_fifo.sv
module drr_len_fifo import drr_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  len_t push_len,
  input  logic pop,
  output len_t head_len,
  output len_t next_len,
  output logic empty,
  output logic full,
  output logic single
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  len_t          mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_len;
  end

  assign head_len = mem[rd_q];
  assign next_len = mem[bump(rd_q)];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign single   = (cnt_q == CW'(1));

  // R10: the scheduler must never push into a full queue
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R5: a grant is only taken from a queue holding a packet
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/drr_active_list.sv
module drr_active_list #(
  parameter int FLOWS = 4,
  parameter int FW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push_a,
  input  logic [FW-1:0] id_a,
  input  logic          push_b,
  input  logic [FW-1:0] id_b,
  output logic [FW-1:0] head_id,
  output logic          empty
);
  localparam int PW = (FLOWS > 1) ? $clog2(FLOWS) : 1;
  localparam int CW = $clog2(FLOWS + 1);

  logic [FW-1:0] ring [FLOWS];
  logic [PW-1:0] hd_q, tl_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] adv(logic [PW-1:0] p, int k);
    int t;
    t = int'(p) + k;
    if (t >= FLOWS) t = t - FLOWS;
    return PW'(t);
  endfunction

  // requeued flow (a) is written before a newly joining flow (b)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < FLOWS; i++) ring[i] <= '0;
    end else begin
      if (push_a) ring[tl_q] <= id_a;
      if (push_b) ring[adv(tl_q, push_a ? 1 : 0)] <= id_b;
      tl_q  <= adv(tl_q, (push_a ? 1 : 0) + (push_b ? 1 : 0));
      if (pop) hd_q <= adv(hd_q, 1);
      cnt_q <= cnt_q + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  assign head_id = ring[hd_q];
  assign empty   = (cnt_q == '0);

  // R6: a flow is listed at most once, so the ring never overfills
  a_r6_ring_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q) + 32'(push_a) + 32'(push_b) - 32'(pop)) <= FLOWS);
  // R7: a turn starts only from a listed flow
  a_r7_pop_listed: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/drr_sched.sv
module drr_sched import drr_pkg::*; #(
  parameter int NUM_FLOWS       = 4,
  parameter int FIFO_DEPTH      = 8,
  parameter int DEFAULT_QUANTUM = 200,
  localparam int FLOW_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  input  logic [FLOW_W-1:0]          enq_flow,
  input  logic [LEN_W-1:0]           enq_len,
  output logic                       enq_ready,
  input  logic [NUM_FLOWS*LEN_W-1:0] quantum_cfg,
  output logic                       gnt_valid,
  input  logic                       gnt_ready,
  output logic [FLOW_W-1:0]          gnt_flow,
  output logic [LEN_W-1:0]           gnt_len
);
  localparam len_t DQ = LEN_W'(DEFAULT_QUANTUM);

  // per-flow queue status
  len_t                 f_head [NUM_FLOWS];
  len_t                 f_next [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] f_empty, f_full, f_single, f_push, f_pop;

  // scheduler state
  def_t                 deficit_q [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] member_q;
  logic                 cur_valid_q;
  logic [FLOW_W-1:0]    cur_q;

  // named events
  logic              flow_ok, enq_fire, join_ev;
  logic              visit_ev, visit_fit, grant_ev;
  logic              same_flow_enq, drained, keep_going, turn_over;
  logic              list_empty, push_a;
  logic [FLOW_W-1:0] vf, id_a;
  def_t              credited, spent;
  len_t              follow_len;

  function automatic len_t quantum_of(logic [FLOW_W-1:0] f);
    return quantum_cfg[f*LEN_W +: LEN_W];
  endfunction

  generate
    if ((1 << FLOW_W) == NUM_FLOWS) begin : g_pow2
      assign flow_ok = 1'b1;
    end else begin : g_npow2
      assign flow_ok = ({1'b0, enq_flow} < (FLOW_W + 1)'(NUM_FLOWS));
    end
  endgenerate

  assign enq_ready = flow_ok && !f_full[enq_flow];
  assign enq_fire  = enq_valid && enq_ready && (enq_len != '0);
  assign join_ev   = enq_fire && !member_q[enq_flow];

  // turn start: credit the quantum, keep the flow if its head fits
  assign visit_ev  = gnt_ready && !cur_valid_q && !list_empty;
  assign credited  = visit_credit(deficit_q[vf], quantum_of(vf), DQ);
  assign visit_fit = head_fits(f_head[vf], credited);

  // grant, with lookahead at the following head to close the turn early
  assign grant_ev      = cur_valid_q && gnt_ready;
  assign spent         = charge(deficit_q[cur_q], f_head[cur_q]);
  assign same_flow_enq = enq_fire && (enq_flow == cur_q);
  assign drained       = grant_ev && f_single[cur_q] && !same_flow_enq;
  assign follow_len    = f_single[cur_q] ? enq_len : f_next[cur_q];
  assign keep_going    = grant_ev && !drained && head_fits(follow_len, spent);
  assign turn_over     = grant_ev && !drained && !keep_going;

  assign push_a = (visit_ev && !visit_fit) || turn_over;
  assign id_a   = visit_ev ? vf : cur_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLOWS; gi++) begin : g_flow
      assign f_push[gi] = enq_fire && (enq_flow == FLOW_W'(gi));
      assign f_pop[gi]  = grant_ev && (cur_q == FLOW_W'(gi));

      drr_len_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (f_push[gi]),
        .push_len (enq_len),
        .pop      (f_pop[gi]),
        .head_len (f_head[gi]),
        .next_len (f_next[gi]),
        .empty    (f_empty[gi]),
        .full     (f_full[gi]),
        .single   (f_single[gi])
      );

      // R5: a flow outside the service order holds no credit
      a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !member_q[gi] |-> (deficit_q[gi] == '0));
      // R6: every listed or served flow has a packet waiting
      a_r6_member_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        member_q[gi] |-> !f_empty[gi]);
    end
  endgenerate

  drr_active_list #(.FLOWS(NUM_FLOWS), .FW(FLOW_W)) u_list (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop     (visit_ev),
    .push_a  (push_a),
    .id_a    (id_a),
    .push_b  (join_ev),
    .id_b    (enq_flow),
    .head_id (vf),
    .empty   (list_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_valid_q <= 1'b0;
      cur_q       <= '0;
      member_q    <= '0;
      for (int i = 0; i < NUM_FLOWS; i++) deficit_q[i] <= '0;
    end else begin
      if (visit_ev && visit_fit) begin
        cur_valid_q <= 1'b1;
        cur_q       <= vf;
      end else if (drained || turn_over) begin
        cur_valid_q <= 1'b0;
      end
      for (int i = 0; i < NUM_FLOWS; i++) begin
        if (visit_ev && (vf == FLOW_W'(i)))
          deficit_q[i] <= credited;
        else if (grant_ev && (cur_q == FLOW_W'(i)))
          deficit_q[i] <= drained ? '0 : spent;
        if (join_ev && (enq_flow == FLOW_W'(i)))
          member_q[i] <= 1'b1;
        else if (drained && (cur_q == FLOW_W'(i)))
          member_q[i] <= 1'b0;
      end
    end
  end

  assign gnt_valid = cur_valid_q;
  assign gnt_flow  = cur_q;
  assign gnt_len   = f_head[cur_q];

  // R3: an offered packet is always covered by its flow's deficit
  a_r3_grant_fits: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (DEF_W'(gnt_len) <= deficit_q[gnt_flow]));
  // R8: a stalled grant is held unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_flow) && $stable(gnt_len)));
  // R9: no scheduling progress while the link is not ready
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_ready |=> ($stable(cur_valid_q) && $stable(cur_q)));
  // R11: a turn whose head fits offers a grant on the next cycle
  a_r11_one_cycle_visit: assert property (@(posedge clk) disable iff (!rst_n)
    (visit_ev && visit_fit) |=> gnt_valid);
endmodule

// File: tb/tb_drr_sched.sv
module tb_drr_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int LW = 11;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0;
  logic [1:0] enq_flow = '0;
  logic [LW-1:0] enq_len = '0;
  logic enq_ready;
  logic [NF*LW-1:0] quantum_cfg;
  logic gnt_valid;
  logic gnt_ready = 1'b0;
  logic [1:0] gnt_flow;
  logic [LW-1:0] gnt_len;

  int qcfg [NF];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NF; i++) quantum_cfg[i*LW +: LW] = LW'(qcfg[i]);
  end

  drr_sched dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_len(enq_len), .enq_ready(enq_ready),
    .quantum_cfg(quantum_cfg),
    .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_flow(gnt_flow), .gnt_len(gnt_len)
  );

  // grant monitor
  int rec_flow [64];
  int rec_len  [64];
  int rec_cyc  [64];
  int rec_n = 0;
  always @(negedge clk) begin
    if (gnt_valid && gnt_ready && rec_n < 64) begin
      rec_flow[rec_n] = int'(gnt_flow);
      rec_len[rec_n]  = int'(gnt_len);
      rec_cyc[rec_n]  = cyc;
      rec_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural round-robin model
  int mq [NF][64];
  int mh [NF];
  int mt [NF];
  int mdef [NF];
  int ord [$];
  int ef [$];
  int el [$];

  task automatic model_enq(int f, int len);
    if (len != 0 && (mt[f] - mh[f]) < DEPTH) begin
      if (mt[f] == mh[f]) ord.push_back(f);
      mq[f][mt[f] % 64] = len;
      mt[f]++;
    end
  endtask

  task automatic model_drain();
    ef.delete(); el.delete();
    while (ord.size() > 0) begin
      int f;
      f = ord.pop_front();
      mdef[f] += (qcfg[f] == 0) ? 200 : qcfg[f];
      while (mh[f] < mt[f] && mq[f][mh[f] % 64] <= mdef[f]) begin
        ef.push_back(f);
        el.push_back(mq[f][mh[f] % 64]);
        mdef[f] -= mq[f][mh[f] % 64];
        mh[f]++;
      end
      if (mh[f] == mt[f]) mdef[f] = 0;
      else ord.push_back(f);
    end
  endtask

  task automatic drv_enq(int f, int len);
    @(negedge clk);
    enq_valid = 1'b1; enq_flow = 2'(f); enq_len = LW'(len);
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic do_enq(int f, int len);
    drv_enq(f, len);
    model_enq(f, len);
  endtask

  task automatic wait_grants(int n);
    for (int k = 0; k < 3000 && rec_n < n; k++) @(negedge clk);
  endtask

  task automatic run_drain(string req);
    model_drain();
    @(negedge clk);
    rec_n = 0;
    gnt_ready = 1'b1;
    wait_grants(ef.size());
    repeat (20) @(negedge clk);
    gnt_ready = 1'b0;
    chk(rec_n == ef.size(), req, rec_n, ef.size());
    for (int i = 0; i < ef.size() && i < rec_n; i++) begin
      chk(rec_flow[i] == ef[i], req, rec_flow[i], ef[i]);
      chk(rec_len[i] == el[i], req, rec_len[i], el[i]);
    end
    chk(gnt_valid == 1'b0, req, int'(gnt_valid), 0);
  endtask

  task automatic t_reset();
    chk(gnt_valid == 1'b0, "R1 no grant", int'(gnt_valid), 0);
    chk(enq_ready == 1'b1, "R1 enq_ready", int'(enq_ready), 1);
    @(negedge clk); gnt_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(gnt_valid == 1'b0, "R1 idle", int'(gnt_valid), 0);
    gnt_ready = 1'b0;
  endtask

  // R2 R3 R4 R7: uneven weights, default quantum, skipped turns
  task automatic t_weighted();
    qcfg[0] = 300; qcfg[1] = 0; qcfg[2] = 100; qcfg[3] = 500;
    do_enq(0, 250); do_enq(1, 150); do_enq(2, 100); do_enq(3, 600);
    do_enq(0, 250); do_enq(1, 100); do_enq(2, 100); do_enq(3, 50);
    do_enq(0, 100); do_enq(1, 300); do_enq(2, 150); do_enq(3, 400);
    run_drain("R2 R3 R4 R7 weighted");
    qcfg[0] = 0; qcfg[1] = 0; qcfg[2] = 0; qcfg[3] = 0;
    do_enq(2, 120); do_enq(3, 90); do_enq(0, 199); do_enq(2, 81);
    do_enq(3, 111); do_enq(0, 2); do_enq(2, 200); do_enq(3, 300);
    run_drain("R3 R7 join order");
  endtask

  // R11 one-cycle visit, R8 back-to-back grants
  task automatic t_b2b();
    qcfg[1] = 2000;
    drv_enq(1, 100); drv_enq(1, 100); drv_enq(1, 100);
    @(negedge clk);
    rec_n = 0;
    gnt_ready = 1'b1;
    @(negedge clk);
    chk(gnt_valid == 1'b1, "R11 grant after visit", int'(gnt_valid), 1);
    wait_grants(3);
    repeat (4) @(negedge clk);
    gnt_ready = 1'b0;
    chk(rec_n == 3, "R8 count", rec_n, 3);
    chk(rec_cyc[1] - rec_cyc[0] == 1, "R8 consecutive", rec_cyc[1] - rec_cyc[0], 1);
    chk(rec_cyc[2] - rec_cyc[1] == 1, "R8 consecutive", rec_cyc[2] - rec_cyc[1], 1);
    qcfg[1] = 0;
  endtask

  // R8 hold under stall, R9 frozen
  task automatic t_stall();
    qcfg[2] = 100;
    drv_enq(2, 60); drv_enq(2, 60);
    @(negedge clk);
    rec_n = 0;
    gnt_ready = 1'b1;
    @(negedge clk);
    gnt_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(gnt_valid && gnt_flow == 2 && gnt_len == 60, "R8 hold", int'(gnt_len), 60);
    end
    chk(rec_n == 0, "R9 no grant while not ready", rec_n, 0);
    gnt_ready = 1'b1;
    wait_grants(2);
    repeat (6) @(negedge clk);
    gnt_ready = 1'b0;
    chk(rec_n == 2, "R8 stall count", rec_n, 2);
    chk(rec_flow[1] == 2 && rec_len[1] == 60, "R4 second turn", rec_len[1], 60);
    qcfg[2] = 0;
  endtask

  // R10 full queue and zero-length drop
  task automatic t_full();
    for (int k = 1; k <= DEPTH; k++) do_enq(3, 10 * k);
    @(negedge clk);
    enq_flow = 2'd3;
    @(negedge clk);
    chk(enq_ready == 1'b0, "R10 full ready", int'(enq_ready), 0);
    enq_flow = 2'd1;
    @(negedge clk);
    chk(enq_ready == 1'b1, "R10 other flow ready", int'(enq_ready), 1);
    do_enq(3, 999);
    do_enq(1, 0);
    do_enq(1, 77);
    run_drain("R10 drop");
  endtask

  // R6 join at back of order, R5 credit cleared on drain
  task automatic t_rejoin();
    qcfg[0] = 100; qcfg[1] = 100; qcfg[2] = 100; qcfg[3] = 100;
    drv_enq(1, 100); drv_enq(1, 100); drv_enq(2, 100);
    @(negedge clk);
    rec_n = 0;
    gnt_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    enq_valid = 1'b1; enq_flow = 2'd0; enq_len = 11'd100;
    @(negedge clk);
    enq_valid = 1'b0;
    wait_grants(4);
    repeat (6) @(negedge clk);
    gnt_ready = 1'b0;
    chk(rec_n == 4, "R6 count", rec_n, 4);
    chk(rec_flow[0] == 1, "R6 order", rec_flow[0], 1);
    chk(rec_flow[1] == 2, "R6 order", rec_flow[1], 2);
    chk(rec_flow[2] == 1, "R6 order", rec_flow[2], 1);
    chk(rec_flow[3] == 0, "R6 joiner last", rec_flow[3], 0);
    // leftover 200 must vanish when flow 0 drains
    qcfg[0] = 300;
    drv_enq(0, 100);
    @(negedge clk); gnt_ready = 1'b1;
    wait_grants(5);
    repeat (4) @(negedge clk);
    gnt_ready = 1'b0;
    drv_enq(0, 400);
    @(negedge clk);
    gnt_ready = 1'b1;
    @(negedge clk);
    chk(gnt_valid == 1'b0, "R5 deficit cleared", int'(gnt_valid), 0);
    @(negedge clk);
    chk(gnt_valid == 1'b1 && gnt_len == 400, "R5 second turn fits", int'(gnt_len), 400);
    repeat (4) @(negedge clk);
    gnt_ready = 1'b0;
    for (int i = 0; i < NF; i++) qcfg[i] = 0;
  endtask

  initial begin
    for (int i = 0; i < NF; i++) begin
      qcfg[i] = 0; mh[i] = 0; mt[i] = 0; mdef[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_weighted();
    t_b2b();
    t_stall();
    t_full();
    t_rejoin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule